// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a stereo PCM stream carried on three wires (a serial data line, a bit clock and a left/right word clock) and turns each channel slot into one 24-bit parallel sample. The bit clock arrives as a single-cycle sampling enable in the system clock domain: the data line and the word clock are sampled only in cycles where that enable is high, and a change of the sampled word clock marks the start of a new channel slot. Each slot is 32 bit clocks long.

Four framing conventions are handled by one deserializer: MSB-first right-justified, MSB-first left-justified, LSB-first right-justified, and I2S. The MSB-first right-justified convention carries 16, 20 or 24 significant bits; all the others always carry 24. Every result is presented MSB-aligned on the 24-bit output with zeros below the received bits, together with a one-cycle valid strobe, a channel flag and a rate tag (1x, 2x or 4x of the base sample rate, the base range being 32 kHz and up to a 192 kHz stream at 4x). Format, word length and rate are static configuration inputs, changed only while reset is held.

Top module: `audioSerialRx`

## Requirements
- R1: While reset is held and in the first cycle after it, outValid is 0, outWord is 0, outIsLeft is 0 and outRate is 1.
- R2: The data line and word clock are sampled only in cycles with bitClkEn high; values in other cycles have no effect, and each outValid pulse comes exactly one clock after a sampling cycle.
- R3: With fmtSel = 01 (MSB-first left-justified) the 24 bits sampled at slot positions 0 to 23 (position 0 being the first sample after the word clock change) form the word MSB first; a sampled word clock of 1 marks the left channel.
- R4: With fmtSel = 11 (I2S) the word occupies slot positions 1 to 24, MSB first, and a sampled word clock of 0 marks the left channel.
- R5: With fmtSel = 00 (MSB-first right-justified) the word is the last L bits sampled before the word clock change, MSB first, with lenSel 00 giving L = 16, 01 giving 20 and 10 giving 24; the output holds those bits in its top L positions and zeros below; the channel is the one whose slot just ended (word clock 1 = left).
- R6: With fmtSel = 10 (LSB-first right-justified) the word is the last 24 bits sampled before the word clock change, least significant bit first, and lenSel has no effect.
- R7: In MSB-first right-justified mode the reserved lenSel code 11 behaves as 24 bits.
- R8: outRate reports the rate multiplier captured with each word: rateSel 00 gives 1, 01 gives 2, 10 gives 4, and the reserved code 11 gives 1.
- R9: outValid pulses for exactly one cycle once per channel slot; nothing is emitted for a partial slot after reset: left-justified and I2S words need a preceding word clock change, and a right-justified word needs at least 24 samples since the previous change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitClkEn | input | 1 | Bit clock sampling enable, one cycle per serial bit |
| sData | input | 1 | Serial data line |
| wordClk | input | 1 | Left/right word clock |
| fmtSel | input | 2 | Framing: 00 MSB RJ, 01 MSB LJ, 10 LSB RJ, 11 I2S |
| lenSel | input | 2 | Word length for MSB RJ: 00 16, 01 20, 10 24, 11 24 |
| rateSel | input | 2 | Rate multiplier: 00 1x, 01 2x, 10 4x, 11 1x |
| outWord | output | 24 | Received sample, MSB-aligned |
| outValid | output | 1 | One-cycle strobe for a completed word |
| outIsLeft | output | 1 | 1 when the word belongs to the left channel |
| outRate | output | 3 | Rate multiplier tag (1, 2 or 4) |

## Verification
The hardest condition to reach is the start of a stream: a right-justified word is only known to be complete at the following word clock change, so the receiver must refuse to emit for the fragment it catches right after reset. Each bench run therefore opens with a short lead-in slot of five bits at the right-channel level before the first full frame and closes with a single trailing bit at the opposite level, so that the exact count of emitted words exposes both spurious and missing strobes. The cycles between sampling enables carry inverted data and an inverted word clock, so any sampling outside the enable corrupts words or creates false slot boundaries.

// File: rtl/audioRxPkg.sv
package audioRxPkg;

  localparam int WORD_W    = 24;
  localparam int SLOT_BITS = 32;
  localparam int CNT_W     = $clog2(SLOT_BITS * 2);
  localparam int RATE_W    = 3;

  typedef enum logic [1:0] {
    FMT_MSB_RJ = 2'b00,
    FMT_MSB_LJ = 2'b01,
    FMT_LSB_RJ = 2'b10,
    FMT_I2S    = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    LEN_16 = 2'b00,
    LEN_20 = 2'b01,
    LEN_24 = 2'b10
  } len_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // shift the sampled bit in
    logic lsbFirst;  // shift direction
    logic takePre;   // emit the register content before this shift
    logic emit;      // a word completes in this cycle
    logic emitLeft;  // channel of the completing word
    len_e len;       // significant length of the completing word
  } dpStrobe_t;

endpackage

// File: rtl/rxControl.sv
module rxControl
  import audioRxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitClkEn,
  input  logic       wordClk,
  input  logic [1:0] fmtSel,
  input  logic [1:0] lenSel,
  output dpStrobe_t  strobe
);

  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] POS_LJEND = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] POS_I2END = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] MIN_FULL  = CNT_W'(WORD_W - 1);

  logic             havePrev;
  logic             prevWclk;
  logic             synced;
  logic [CNT_W-1:0] bitCnt;

  logic             toggle;
  logic [CNT_W-1:0] posNow;
  logic             fullSlot;
  fmt_e             fmt;
  logic             rjEmit;
  logic             ljEmit;
  logic             i2sEmit;

  assign fmt      = fmt_e'(fmtSel);
  assign toggle   = bitClkEn && havePrev && (wordClk != prevWclk);
  assign fullSlot = synced && (bitCnt >= MIN_FULL);

  always_comb begin
    if (toggle)
      posNow = '0;
    else if (bitCnt == CNT_MAX)
      posNow = CNT_MAX;
    else
      posNow = bitCnt + 1'b1;
  end

  assign rjEmit  = toggle && fullSlot;
  assign ljEmit  = bitClkEn && synced && !toggle && (posNow == POS_LJEND);
  assign i2sEmit = bitClkEn && synced && !toggle && (posNow == POS_I2END);

  always_comb begin
    strobe          = '0;
    strobe.shiftEn  = bitClkEn;
    strobe.lsbFirst = (fmt == FMT_LSB_RJ);
    strobe.len      = LEN_24;
    unique case (fmt)
      FMT_MSB_RJ: begin
        strobe.emit     = rjEmit;
        strobe.takePre  = 1'b1;
        strobe.emitLeft = prevWclk;
        strobe.len      = (lenSel == 2'b11) ? LEN_24 : len_e'(lenSel);
      end
      FMT_LSB_RJ: begin
        strobe.emit     = rjEmit;
        strobe.takePre  = 1'b1;
        strobe.emitLeft = prevWclk;
      end
      FMT_MSB_LJ: begin
        strobe.emit     = ljEmit;
        strobe.emitLeft = wordClk;
      end
      default: begin
        strobe.emit     = i2sEmit;
        strobe.emitLeft = !wordClk;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      havePrev <= 1'b0;
      prevWclk <= 1'b0;
      synced   <= 1'b0;
      bitCnt   <= '0;
    end else if (bitClkEn) begin
      havePrev <= 1'b1;
      prevWclk <= wordClk;
      bitCnt   <= posNow;
      if (toggle)
        synced <= 1'b1;
    end
  end

endmodule

// File: rtl/rxDatapath.sv
module rxDatapath
  import audioRxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sData,
  input  logic [1:0]        rateSel,
  input  dpStrobe_t         strobe,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid,
  output logic              outIsLeft,
  output logic [RATE_W-1:0] outRate
);

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] shiftNext;
  logic [WORD_W-1:0] srcWord;
  logic [WORD_W-1:0] aligned;
  logic [RATE_W-1:0] rateTag;

  assign shiftNext = strobe.lsbFirst ? {sData, shiftReg[WORD_W-1:1]}
                                     : {shiftReg[WORD_W-2:0], sData};
  assign srcWord   = strobe.takePre ? shiftReg : shiftNext;

  always_comb begin
    unique case (strobe.len)
      LEN_16:  aligned = srcWord << (WORD_W - 16);
      LEN_20:  aligned = srcWord << (WORD_W - 20);
      default: aligned = srcWord;
    endcase
  end

  always_comb begin
    unique case (rateSel)
      2'b01:   rateTag = RATE_W'(2);
      2'b10:   rateTag = RATE_W'(4);
      default: rateTag = RATE_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      shiftReg <= '0;
    else if (strobe.shiftEn)
      shiftReg <= shiftNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outWord   <= '0;
      outValid  <= 1'b0;
      outIsLeft <= 1'b0;
      outRate   <= RATE_W'(1);
    end else begin
      outValid <= strobe.emit;
      if (strobe.emit) begin
        outWord   <= aligned;
        outIsLeft <= strobe.emitLeft;
        outRate   <= rateTag;
      end
    end
  end

endmodule

// File: rtl/audioSerialRx.sv
module audioSerialRx
  import audioRxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClkEn,
  input  logic              sData,
  input  logic              wordClk,
  input  logic [1:0]        fmtSel,
  input  logic [1:0]        lenSel,
  input  logic [1:0]        rateSel,
  output logic [WORD_W-1:0] outWord,
  output logic              outValid,
  output logic              outIsLeft,
  output logic [RATE_W-1:0] outRate
);

  dpStrobe_t strobe;

  rxControl i_rxControl (
    .clk      (clk),
    .rstN     (rstN),
    .bitClkEn (bitClkEn),
    .wordClk  (wordClk),
    .fmtSel   (fmtSel),
    .lenSel   (lenSel),
    .strobe   (strobe)
  );

  rxDatapath i_rxDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .sData     (sData),
    .rateSel   (rateSel),
    .strobe    (strobe),
    .outWord   (outWord),
    .outValid  (outValid),
    .outIsLeft (outIsLeft),
    .outRate   (outRate)
  );

endmodule

// File: rtl/rxChecker.sv
module rxChecker
  import audioRxPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              bitClkEn,
  input logic              wordClk,
  input logic [1:0]        fmtSel,
  input logic [1:0]        lenSel,
  input logic [WORD_W-1:0] outWord,
  input logic              outValid,
  input logic              outIsLeft,
  input logic [RATE_W-1:0] outRate
);

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R9

  AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(bitClkEn)); // R2

  AST_RATE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(outRate) == 1); // R8

  AST_RJ16_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && fmtSel == 2'b00 && lenSel == 2'b00) |-> (outWord[7:0] == 8'h00)); // R5

  AST_RJ20_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && fmtSel == 2'b00 && lenSel == 2'b01) |-> (outWord[3:0] == 4'h0)); // R5

  AST_LJ_CHANNEL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && fmtSel == 2'b01) |-> (outIsLeft == $past(wordClk))); // R3

  AST_I2S_CHANNEL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && fmtSel == 2'b11) |-> (outIsLeft == !$past(wordClk))); // R4

endmodule

bind audioSerialRx rxChecker i_rxChecker (
  .clk       (clk),
  .rstN      (rstN),
  .bitClkEn  (bitClkEn),
  .wordClk   (wordClk),
  .fmtSel    (fmtSel),
  .lenSel    (lenSel),
  .outWord   (outWord),
  .outValid  (outValid),
  .outIsLeft (outIsLeft),
  .outRate   (outRate)
);

// File: tb/test_audioSerialRx.sv
module test_audioSerialRx;

  localparam int CLK_PERIOD = 10;
  localparam int MAXQ       = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitClkEn = 1'b0;
  logic        sData = 1'b0;
  logic        wordClk = 1'b0;
  logic [1:0]  fmtSel = 2'b00;
  logic [1:0]  lenSel = 2'b00;
  logic [1:0]  rateSel = 2'b00;
  logic [23:0] outWord;
  logic        outValid;
  logic        outIsLeft;
  logic [2:0]  outRate;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [23:0] expWord [MAXQ];
  logic        expLeft [MAXQ];
  int          expCnt = 0;
  int          obsCnt = 0;
  logic [2:0]  expRate = 3'd1;
  string       curTag = "R3";
  logic        enAtEdge = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  audioSerialRx i_audioSerialRx (
    .clk (clk), .rstN (rstN), .bitClkEn (bitClkEn), .sData (sData),
    .wordClk (wordClk), .fmtSel (fmtSel), .lenSel (lenSel), .rateSel (rateSel),
    .outWord (outWord), .outValid (outValid), .outIsLeft (outIsLeft),
    .outRate (outRate)
  );

  always @(posedge clk) enAtEdge <= bitClkEn;

  task automatic check(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, expv);
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      check(enAtEdge, "R2 valid one clock after a sample", 32'(enAtEdge), 32'd1);
      if (obsCnt < expCnt) begin
        check(outWord == expWord[obsCnt], {curTag, " word"}, 32'(outWord),
              32'(expWord[obsCnt]));
        check(outIsLeft == expLeft[obsCnt], {curTag, " channel"}, 32'(outIsLeft),
              32'(expLeft[obsCnt]));
        check(outRate == expRate, "R8 rate tag", 32'(outRate), 32'(expRate));
      end else begin
        check(1'b0, "R9 extra word", 32'(obsCnt), 32'(expCnt));
      end
      obsCnt++;
    end
  end

  task automatic sendBit(input logic b, input logic lv);
    @(negedge clk);
    sData = b; wordClk = lv; bitClkEn = 1'b1;
    @(negedge clk);
    bitClkEn = 1'b0; sData = ~b; wordClk = ~lv;  // ignored between samples
  endtask

  function automatic int wordLen(input logic [1:0] f, input logic [1:0] l);
    if (f != 2'b00) return 24;
    if (l == 2'b00) return 16;
    if (l == 2'b01) return 20;
    return 24;
  endfunction

  function automatic logic slotBit(input logic [1:0] f, input int len,
                                   input logic [23:0] w, input int i);
    case (f)
      2'b01:   return (i < 24) ? w[23 - i] : 1'b1;
      2'b11:   return (i >= 1 && i <= 24) ? w[24 - i] : 1'b1;
      2'b10:   return (i >= 8) ? w[i - 8] : 1'b1;
      default: return (i >= 32 - len) ? w[len - 1 - (i - (32 - len))] : 1'b1;
    endcase
  endfunction

  task automatic sendSlot(input logic [23:0] w, input logic lv, input logic left,
                          input int len);
    expWord[expCnt] = w << (24 - len);
    expLeft[expCnt] = left;
    expCnt++;
    for (int i = 0; i < 32; i++) sendBit(slotBit(fmtSel, len, w, i), lv);
  endtask

  task automatic applyReset(input logic [1:0] f, input logic [1:0] l,
                            input logic [1:0] r);
    @(negedge clk);
    rstN = 1'b0; bitClkEn = 1'b0;
    fmtSel = f; lenSel = l; rateSel = r;
    repeat (3) @(negedge clk);
    expCnt = 0; obsCnt = 0;
    rstN = 1'b1;
  endtask

  task automatic runTest(input logic [1:0] f, input logic [1:0] l,
                         input logic [1:0] r, input int seed, input string tag);
    int len;
    logic leftLv;
    logic [23:0] w;
    applyReset(f, l, r);
    curTag = tag;
    len = wordLen(f, l);
    expRate = (r == 2'b01) ? 3'd2 : (r == 2'b10) ? 3'd4 : 3'd1;
    leftLv = (f == 2'b11) ? 1'b0 : 1'b1;
    for (int i = 0; i < 5; i++) sendBit(1'b1, ~leftLv);  // partial lead-in slot
    for (int fr = 0; fr < 3; fr++) begin
      for (int ch = 0; ch < 2; ch++) begin
        if (fr == 0 && ch == 0) w = 24'(1) << (len - 1);
        else if (fr == 0) w = 24'hFFFFFF;
        else w = 24'(seed * 32'h9E3779B1 + (fr * 2 + ch) * 32'h01000193);
        w = w & ((24'(1) << len) - 24'(1) | ((len == 24) ? 24'hFFFFFF : 24'h0));
        sendSlot(w, (ch == 0) ? leftLv : ~leftLv, (ch == 0), len);
      end
    end
    sendBit(1'b1, leftLv);  // closing word clock change
    repeat (4) @(negedge clk);
    check(obsCnt == expCnt, {"R9 word count ", tag}, 32'(obsCnt), 32'(expCnt));
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", 32'(outValid), 32'd0);
    check(outWord == 24'd0, "R1 outWord in reset", 32'(outWord), 32'd0);
    check(outIsLeft == 1'b0, "R1 outIsLeft in reset", 32'(outIsLeft), 32'd0);
    check(outRate == 3'd1, "R1 outRate in reset", 32'(outRate), 32'd1);

    runTest(2'b00, 2'b00, 2'b00, 11, "R5 rj16");
    runTest(2'b00, 2'b01, 2'b01, 22, "R5 rj20");
    runTest(2'b00, 2'b10, 2'b10, 33, "R5 rj24");
    runTest(2'b00, 2'b11, 2'b11, 44, "R7 rj-reserved");
    runTest(2'b01, 2'b00, 2'b01, 55, "R3 lj");
    runTest(2'b01, 2'b10, 2'b11, 66, "R3 lj");
    runTest(2'b10, 2'b00, 2'b10, 77, "R6 lsb len00");
    runTest(2'b10, 2'b01, 2'b00, 88, "R6 lsb len01");
    runTest(2'b11, 2'b00, 2'b00, 99, "R4 i2s");
    runTest(2'b11, 2'b01, 2'b10, 12, "R4 i2s");

    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0 && outRate == 3'd1, "R1 state after late reset",
          {28'd0, outValid, outRate}, 32'd1);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule